// File: doc/BRIEF.md
# Speculative Output Queue Port Buffer

This block connects a processor pipeline to an external synchronous FIFO and carries instruction results out as queue pushes. A two-entry buffer accepts at most one result per cycle. An entry written by an instruction that is still in flight stays speculative until the pipeline pulses `commit`. A `kill` pulse discards every entry that has not yet been committed. Only committed entries leave the block. They go out in arrival order through a registered push strobe and a registered data bus. A drain happens only in a cycle where the external FIFO's full flag is low.

The pipeline watches `wr_stall`. It is raised when a result is offered, both entries are held, and no entry drains in that cycle. A separate status, `q_full`, reports that both entries are occupied. Software can read it and skip a push rather than stall. The data width is a parameter and may be as wide as 1024 bits.

Top module: `spec_oq_buf`

## Requirements
- R1: With the external FIFO not full, a producer that offers one result every cycle and commits each one a cycle later is never stalled.
- R2: The buffer holds exactly two entries. After two accepted writes with nothing drained, `q_full` is 1.
- R3: `wr_stall` is 1 exactly when `wr_valid` is 1, `kill` is 0, both entries are held, and no committed entry drains in that cycle. A stalled value is not stored.
- R4: `fifo_push` is 1 in a cycle only if `fifo_full` was 0 in the cycle before.
- R5: `fifo_push` and `fifo_data` are registered. An entry written at clock edge N and committed at edge N+1 appears on `fifo_push`/`fifo_data` right after edge N+2, provided `fifo_full` is 0.
- R6: A speculative entry never reaches `fifo_push`. `commit` marks the oldest entry that was held and uncommitted at the start of the cycle; a write in that same cycle is not committed by it. Committed entries leave in the order in which they were written.
- R7: `kill` discards every uncommitted entry and the write offered in the same cycle. A `commit` in the same cycle takes effect before the `kill`.
- R8: `q_full` reports two held entries whatever the value of `wr_valid`. With `wr_valid` at 0, `wr_stall` is 0.
- R9: During and after reset the buffer is empty, `fifo_push` is 0, `q_full` is 0 and `wr_stall` is 0.
- R10: All `DATA_W` bits of a value, including the top bit, arrive at `fifo_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Pipeline offers a result this cycle |
| wr_data | input | DATA_W | Result value |
| wr_stall | output | 1 | Offered result not taken; the pipeline holds it |
| q_full | output | 1 | Both entries occupied (non-blocking status) |
| commit | input | 1 | Oldest speculative entry becomes committed |
| kill | input | 1 | Discard all uncommitted entries and this cycle's write |
| fifo_full | input | 1 | External FIFO full flag |
| fifo_push | output | 1 | Registered push strobe to the external FIFO |
| fifo_data | output | DATA_W | Registered push data |

## Verification
A wrong occupancy count shows up in one of two ways. Either `q_full` or `wr_stall` takes the wrong value in the very cycle the count diverges, or an extra or missing push appears within two cycles. A wrong committed count or a lost kill lets a speculative value surface at `fifo_push`. It does so one edge after the bad drain decision, and the scoreboard catches it as an unexpected or misordered item. A pointer error surfaces as the wrong `fifo_data` on the next push.

// File: rtl/spec_oq_pkg.sv
package spec_oq_pkg;
  parameter int unsigned DEF_DEPTH  = 2;
  parameter int unsigned DEF_DATA_W = 64;
endpackage

// File: rtl/oq_store.sv
module oq_store #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/oq_ctrl.sv
module oq_ctrl #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic          commit,
  input  logic          kill,
  input  logic          fifo_full,
  output logic          wr_en,
  output logic          wr_stall,
  output logic          q_full,
  output logic          drain,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] cmt
);
  logic [CW-1:0] occ_q, cmt_q, cmt_mid, occ_mid;
  logic [PW-1:0] rd_q;
  logic          room, cadd;

  // committed entries form the oldest prefix; only the head may leave
  assign drain    = (cmt_q != '0) && !fifo_full;
  assign room     = (occ_q != CW'(DEPTH)) || drain;
  assign wr_en    = wr_valid && room && !kill;
  assign wr_stall = wr_valid && !room && !kill;
  assign q_full   = (occ_q == CW'(DEPTH));
  assign cadd     = commit && (cmt_q != occ_q);
  assign wr_ptr   = rd_q + occ_q[PW-1:0];
  assign rd_ptr   = rd_q;

  always_comb begin
    cmt_mid = cmt_q - CW'(drain) + CW'(cadd);
    occ_mid = kill ? cmt_mid : (occ_q - CW'(drain));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
    end else begin
      occ_q <= occ_mid + CW'(wr_en);
      cmt_q <= cmt_mid;
      if (drain) rd_q <= rd_q + PW'(1);
    end
  end

  assign occ = occ_q;
  assign cmt = cmt_q;
endmodule

// File: rtl/oq_drain.sv
module oq_drain #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drain,
  input  logic [DATA_W-1:0] head_data,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_data
);
  always_ff @(posedge clk) begin
    if (rst) fifo_push <= 1'b0;
    else     fifo_push <= drain;
  end

  always_ff @(posedge clk) begin
    if (drain) fifo_data <= head_data;
  end
endmodule

// File: rtl/spec_oq_buf.sv
module spec_oq_buf #(
  parameter int unsigned DATA_W = spec_oq_pkg::DEF_DATA_W,
  parameter int unsigned DEPTH  = spec_oq_pkg::DEF_DEPTH,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_stall,
  output logic              q_full,
  input  logic              commit,
  input  logic              kill,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_data
);
  logic              wr_en, drain;
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     occ, cmt;
  logic [DATA_W-1:0] head_data;

  oq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .commit(commit), .kill(kill),
    .fifo_full(fifo_full), .wr_en(wr_en), .wr_stall(wr_stall), .q_full(q_full),
    .drain(drain), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ), .cmt(cmt)
  );

  oq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(head_data)
  );

  oq_drain #(.DATA_W(DATA_W)) drain_i (
    .clk(clk), .rst(rst), .drain(drain), .head_data(head_data),
    .fifo_push(fifo_push), .fifo_data(fifo_data)
  );
endmodule

// File: rtl/spec_oq_chk.sv
module spec_oq_chk #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          wr_stall,
  input logic          q_full,
  input logic          kill,
  input logic          fifo_full,
  input logic          fifo_push,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] cmt
);
  // R4
  push_gate_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !$past(fifo_full));

  // R6
  commit_first_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> ($past(cmt) != '0));

  // R3
  stall_full_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stall |-> (q_full && wr_valid));

  // R7
  kill_clear_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> (occ == cmt));

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (occ <= CW'(DEPTH)) && (cmt <= occ));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!fifo_push && !q_full && (occ == '0)));
endmodule

bind spec_oq_buf spec_oq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_stall(wr_stall),
  .q_full(q_full), .kill(kill), .fifo_full(fifo_full),
  .fifo_push(fifo_push), .occ(occ), .cmt(cmt)
);

// File: tb/spec_oq_buf_tb.sv
module spec_oq_buf_tb_top;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         commit = 1'b0;
  logic         kill = 1'b0;
  logic         fifo_full = 1'b0;
  logic         wr_stall, q_full, fifo_push;
  logic [W-1:0] fifo_data;

  int nchk = 0;
  int nfail = 0;
  int npush = 0;
  logic full_at_edge = 1'b0;
  logic [W-1:0] spec_q[$];
  logic [W-1:0] exp_q[$];

  always #4 clk = ~clk;

  spec_oq_buf #(.DATA_W(W), .DEPTH(2)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_stall(wr_stall), .q_full(q_full), .commit(commit), .kill(kill),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_data(fifo_data)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) full_at_edge <= fifo_full;

  // monitor: compare every push with the scoreboard
  always @(negedge clk) begin
    if (!rst && fifo_push) begin
      npush++;
      chk(!full_at_edge, "R4 push while full", W'(full_at_edge), '0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected push", fifo_data, '0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(fifo_data == e, "R6/R10 push data", fifo_data, e);
      end
    end
  end

  // driver: one cycle of stimulus, scoreboard updated in commit, kill, write order
  task automatic step(input logic v, input logic [W-1:0] d, input logic c,
                      input logic k, output logic st);
    wr_valid = v; wr_data = d; commit = c; kill = k;
    #1 st = wr_stall;
    @(posedge clk);
    if (c && spec_q.size() > 0) exp_q.push_back(spec_q.pop_front());
    if (k) spec_q.delete();
    if (v && !st && !k) spec_q.push_back(d);
    @(negedge clk);
    wr_valid = 1'b0; commit = 1'b0; kill = 1'b0;
  endtask

  task automatic idle(input int n);
    logic s;
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, s);
  endtask

  initial begin
    #160000;
    chk(1'b0, "watchdog expired", '0, '0);
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic st;
    logic [W-1:0] a, b, c, d, e, f, g, h, i2, j;
    int stalls;
    int base;
    a  = {8'hA1, {(W-16){1'b0}}, 8'h01};
    b  = {8'hB2, {(W-16){1'b1}}, 8'h02};
    c  = {W{1'b1}};
    d  = {W/2{2'b01}};
    e  = {W/2{2'b10}};
    f  = {1'b1, {(W-2){1'b0}}, 1'b1};
    g  = {W/4{4'h5}};
    h  = {W/8{8'h3C}};
    i2 = {W/8{8'hC3}};
    j  = {W/16{16'hBEEF}};

    repeat (3) @(negedge clk);
    // R9 during reset
    chk(!fifo_push && !q_full && !wr_stall, "R9 in reset", W'({fifo_push, q_full, wr_stall}), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(!fifo_push && !q_full && !wr_stall, "R9 after reset", W'({fifo_push, q_full, wr_stall}), '0);

    // R2, R3, R8: fill while downstream is full
    fifo_full = 1'b1;
    step(1'b1, a, 1'b0, 1'b0, st);
    chk(!st, "R3 first write not stalled", W'(st), '0);
    step(1'b1, b, 1'b0, 1'b0, st);
    chk(q_full, "R2 two entries held", W'(q_full), 1);
    step(1'b1, c, 1'b0, 1'b0, st);
    chk(st, "R3 third write stalls", W'(st), 1);
    #1;
    chk(q_full && !wr_stall, "R8 status without wr_valid", W'({q_full, wr_stall}), 2);
    // R6: speculative entries stay put once the FIFO has room
    fifo_full = 1'b0;
    idle(4);
    chk(npush == 0, "R6 no speculative push", W'(npush), 0);

    // R7: commit and kill in one cycle -> A kept, B discarded
    step(1'b0, '0, 1'b1, 1'b1, st);
    idle(4);
    chk(npush == 1 && exp_q.size() == 0, "R7 commit before kill", W'(npush), 1);
    chk(!q_full, "R7 buffer emptied", W'(q_full), 0);

    // R7: kill drops the same-cycle write; R6 commit skips a same-cycle write
    step(1'b1, d, 1'b0, 1'b0, st);
    step(1'b1, e, 1'b0, 1'b1, st);
    idle(3);
    chk(npush == 1, "R7 killed entries never pushed", W'(npush), 1);
    step(1'b1, f, 1'b1, 1'b0, st);
    idle(3);
    chk(npush == 1, "R6 commit ignores same-cycle write", W'(npush), 1);
    step(1'b0, '0, 1'b1, 1'b0, st);
    idle(3);
    chk(npush == 2, "R10 wide value pushed", W'(npush), 2);

    // R5: latency
    step(1'b1, g, 1'b0, 1'b0, st);
    step(1'b0, '0, 1'b1, 1'b0, st);
    chk(!fifo_push, "R5 no push right after commit edge", W'(fifo_push), 0);
    step(1'b0, '0, 1'b0, 1'b0, st);
    chk(fifo_push && fifo_data == g, "R5 push one edge later", fifo_data, g);
    idle(1);
    chk(!fifo_push, "R5 push lasts one cycle", W'(fifo_push), 0);

    // R1: full-rate stream
    stalls = 0;
    base = npush;
    for (int k = 0; k < 12; k++) begin
      step(1'b1, ({W{1'b1}} << k) ^ W'(k * 7 + 3), k > 0, 1'b0, st);
      if (st) stalls++;
    end
    step(1'b0, '0, 1'b1, 1'b0, st);
    idle(4);
    chk(stalls == 0, "R1 stream never stalls", W'(stalls), 0);
    chk(npush - base == 12 && exp_q.size() == 0, "R1 stream all delivered", W'(npush - base), 12);

    // R4 and R3 under backpressure
    fifo_full = 1'b1;
    step(1'b1, h, 1'b0, 1'b0, st);
    step(1'b1, i2, 1'b1, 1'b0, st);
    step(1'b0, '0, 1'b1, 1'b0, st);
    base = npush;
    idle(3);
    chk(npush == base, "R4 no push while full", W'(npush - base), 0);
    step(1'b1, j, 1'b0, 1'b0, st);
    chk(st, "R3 stall when full and no drain", W'(st), 1);
    fifo_full = 1'b0;
    idle(4);
    chk(npush - base == 2 && exp_q.size() == 0, "R6 committed drain in order", W'(npush - base), 2);
    chk(!q_full && spec_q.size() == 0, "R2 empty at end", W'(q_full), 0);

    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule